// File: doc/BRIEF.md
# Adjacent-Error-Correcting Protected RAM

This block is a memory with one write port and one read port. Every 32-bit data word is stored together with eight check bits, which makes a 40-bit codeword. The check bits are computed when the word is written. When a word is read, the codeword is decoded, and each read result carries two status flags next to the data.

The code corrects any one flipped bit. It also corrects any two flipped bits that sit next to each other in the codeword. Three flipped bits in a row are detected but not repaired: the word is flagged as uncorrectable and its raw data bits are returned as stored. The check matrix is derived when the design elaborates. The first eight columns are unit vectors for the check bits, and each data column is picked by a greedy search. The search keeps every single-bit and adjacent-pair syndrome distinct and nonzero, and keeps every adjacent-triple syndrome apart from all of them.

A parameter can add one register between the storage read and the decoder. This costs one cycle of latency and shortens the path into the decoder. For test, a debug port XORs a chosen 40-bit mask into any stored codeword, so faults can be injected.

Top module: `ecc_adj_ram`

## Requirements
- R1: A written word is stored as a 40-bit codeword with data in bits [39:8] and check bits in [7:0]. Reading it back with no injected fault returns the same data with both flags clear.
- R2: When exactly one codeword bit (data or check) is flipped, the read returns the original data with the error flag set and the uncorrectable flag clear.
- R3: When two adjacent codeword bits are flipped, the read returns the original data with the error flag set and the uncorrectable flag clear. At most one correction candidate ever matches a syndrome.
- R4: When three adjacent codeword bits are flipped, both flags are set. The returned data equals the stored data bits [39:8] uncorrected. The uncorrectable flag never appears without the error flag.
- R5: The read word rd_q is 34 bits wide. Bits [31:0] hold the data, bit 32 is the error flag and bit 33 is the uncorrectable flag.
- R6: rd_valid pulses exactly 1 + PIPE_STAGE cycles after the clock edge that samples rd_en. rd_q holds the matching word in that cycle.
- R7: A debug strobe XORs dbg_flip into the codeword at dbg_addr. If a write targets the same address in the same cycle, the write wins and the flip is ignored.
- R8: A read and a write to the same address in the same cycle return the contents stored before that write.
- R9: Just after reset, rd_valid is 0 and rd_q is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset for the read pipeline |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | $clog2(DEPTH) | Write address |
| wr_data | input | 32 | Write data |
| dbg_en | input | 1 | Fault-injection strobe |
| dbg_addr | input | $clog2(DEPTH) | Fault-injection address |
| dbg_flip | input | 40 | Codeword bits to invert |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | $clog2(DEPTH) | Read address |
| rd_valid | output | 1 | Read result valid |
| rd_q | output | 34 | {uncorrectable, error, data[31:0]} |

## Verification
The bench sweeps every single-bit mask, every adjacent-pair mask and every adjacent-triple mask across all 40 codeword positions, each over fresh random data. The sweep shows that each fault class is decoded as its own kind, and that faults in the check-bit field are repaired as well as faults in the data field. Clean random words and all-zero and all-ones data separate the zero-syndrome path from the correcting path. Both pipeline settings run side by side on the same stimulus, so latency faults show up as a mismatch between them. Directed collisions check the order of write against fault injection and of write against read.

// File: rtl/ecc_adj_pkg.sv
package ecc_adj_pkg;
  localparam int DATA_W = 32;
  localparam int CHK_W  = 8;
  localparam int CODE_W = DATA_W + CHK_W;
  localparam int PAIR_N = CODE_W - 1;
  localparam int HIT_W  = CODE_W + PAIR_N;
  localparam int SYN_N  = 1 << CHK_W;

  // Greedy column search: unit vectors for the check bits, then for each
  // data position the smallest syndrome keeping single/pair syndromes unique
  // and adjacent-triple syndromes outside the correctable set.
  function automatic logic [CODE_W*CHK_W-1:0] build_cols();
    logic [SYN_N-1:0] corr;
    logic [SYN_N-1:0] trip;
    logic [CODE_W*CHK_W-1:0] cols;
    logic [CHK_W-1:0] p1, p2, c, d, t;
    logic found, ok;
    corr = '0; trip = '0; cols = '0;
    p1 = '0; p2 = '0; c = '0; d = '0; t = '0;
    for (int i = 0; i < CODE_W; i++) begin
      found = 1'b0;
      for (int k = 1; k < SYN_N; k++) begin
        if (!found) begin
          c  = CHK_W'(k);
          ok = (i < CHK_W) ? (k == (1 << i)) : 1'b1;
          d  = c ^ p1;
          t  = d ^ p2;
          if (corr[c] || trip[c]) ok = 1'b0;
          if (i > 0 && (d == '0 || corr[d] || trip[d] || d == c)) ok = 1'b0;
          if (i > 1 && (t == '0 || corr[t] || t == c || t == d)) ok = 1'b0;
          if (ok) found = 1'b1;
        end
      end
      cols[i*CHK_W +: CHK_W] = c;
      corr[c] = 1'b1;
      if (i > 0) corr[d] = 1'b1;
      if (i > 1) trip[t] = 1'b1;
      p2 = p1;
      p1 = c;
    end
    return cols;
  endfunction

  localparam logic [CODE_W*CHK_W-1:0] H_COLS = build_cols();

  function automatic logic [CHK_W-1:0] col(input int i);
    return H_COLS[i*CHK_W +: CHK_W];
  endfunction

  function automatic logic [CHK_W-1:0] syndrome(input logic [CODE_W-1:0] w);
    logic [CHK_W-1:0] s;
    s = '0;
    for (int i = 0; i < CODE_W; i++)
      if (w[i]) s = s ^ col(i);
    return s;
  endfunction

  // Check columns are unit vectors, so the check bits equal the data syndrome.
  function automatic logic [CODE_W-1:0] encode(input logic [DATA_W-1:0] d);
    logic [CODE_W-1:0] w;
    w = {d, {CHK_W{1'b0}}};
    return {d, syndrome(w)};
  endfunction
endpackage

// File: rtl/ecc_adj_enc.sv
module ecc_adj_enc
  import ecc_adj_pkg::*;
(
  input  logic [DATA_W-1:0] data,
  output logic [CODE_W-1:0] code
);
  assign code = encode(data);
endmodule

// File: rtl/ecc_adj_store.sv
module ecc_adj_store #(
  parameter int DEPTH  = 64,
  parameter int CODE_W = 40,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [CODE_W-1:0] wr_code,
  input  logic              dbg_en,
  input  logic [AW-1:0]     dbg_addr,
  input  logic [CODE_W-1:0] dbg_flip,
  input  logic              rd_en,
  input  logic [AW-1:0]     rd_addr,
  output logic [CODE_W-1:0] rd_code,
  output logic              rd_vld
);
  logic [CODE_W-1:0] mem [DEPTH];
  logic dbg_blocked;

  assign dbg_blocked = wr_en && (wr_addr == dbg_addr);

  always_ff @(posedge clk) begin
    if (dbg_en && !dbg_blocked)
      mem[dbg_addr] <= mem[dbg_addr] ^ dbg_flip;
    if (wr_en)
      mem[wr_addr] <= wr_code;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_code <= '0;
      rd_vld  <= 1'b0;
    end else begin
      rd_vld <= rd_en;
      if (rd_en) rd_code <= mem[rd_addr];
    end
  end
endmodule

// File: rtl/ecc_adj_dec.sv
module ecc_adj_dec
  import ecc_adj_pkg::*;
(
  input  logic [CODE_W-1:0] code,
  output logic [DATA_W-1:0] data,
  output logic              err,
  output logic              ue,
  output logic [HIT_W-1:0]  hit_vec
);
  logic [CHK_W-1:0]  syn;
  logic [CODE_W-1:0] flip;
  logic              syn_nz;
  logic              hit_any;

  assign syn = syndrome(code);

  for (genvar g = 0; g < CODE_W; g++) begin : g_single
    assign hit_vec[g] = (syn == col(g));
  end
  for (genvar g = 0; g < PAIR_N; g++) begin : g_pair
    assign hit_vec[CODE_W+g] = (syn == (col(g) ^ col(g + 1)));
  end

  for (genvar g = 0; g < CODE_W; g++) begin : g_flip
    if (g == 0) begin : g_lo
      assign flip[g] = hit_vec[g] | hit_vec[CODE_W+g];
    end else if (g == CODE_W - 1) begin : g_hi
      assign flip[g] = hit_vec[g] | hit_vec[CODE_W+g-1];
    end else begin : g_mid
      assign flip[g] = hit_vec[g] | hit_vec[CODE_W+g] | hit_vec[CODE_W+g-1];
    end
  end

  assign syn_nz  = (syn != '0);
  assign hit_any = |hit_vec;
  assign err     = syn_nz;
  assign ue      = syn_nz && !hit_any;
  assign data    = code[CODE_W-1:CHK_W] ^ flip[CODE_W-1:CHK_W];
endmodule

// File: rtl/ecc_adj_ram.sv
module ecc_adj_ram
  import ecc_adj_pkg::*;
#(
  parameter int DEPTH      = 64,
  parameter int PIPE_STAGE = 0,
  localparam int AW        = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              dbg_en,
  input  logic [AW-1:0]     dbg_addr,
  input  logic [CODE_W-1:0] dbg_flip,
  input  logic              rd_en,
  input  logic [AW-1:0]     rd_addr,
  output logic              rd_valid,
  output logic [DATA_W+1:0] rd_q
);
  logic [CODE_W-1:0] wr_code;
  logic [CODE_W-1:0] mem_code;
  logic              mem_vld;
  logic [CODE_W-1:0] dec_code;
  logic              dec_vld;
  logic [DATA_W-1:0] dec_data;
  logic              dec_err;
  logic              dec_ue;
  logic [HIT_W-1:0]  hit_vec;

  ecc_adj_enc u_enc (.data(wr_data), .code(wr_code));

  ecc_adj_store #(.DEPTH(DEPTH), .CODE_W(CODE_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_code(wr_code),
    .dbg_en(dbg_en), .dbg_addr(dbg_addr), .dbg_flip(dbg_flip),
    .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_code(mem_code), .rd_vld(mem_vld)
  );

  if (PIPE_STAGE != 0) begin : g_pipe
    logic [CODE_W-1:0] pipe_code;
    logic              pipe_vld;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pipe_code <= '0;
        pipe_vld  <= 1'b0;
      end else begin
        pipe_vld <= mem_vld;
        if (mem_vld) pipe_code <= mem_code;
      end
    end
    assign dec_code = pipe_code;
    assign dec_vld  = pipe_vld;
  end else begin : g_direct
    assign dec_code = mem_code;
    assign dec_vld  = mem_vld;
  end

  ecc_adj_dec u_dec (
    .code(dec_code), .data(dec_data), .err(dec_err), .ue(dec_ue), .hit_vec(hit_vec)
  );

  assign rd_q     = {dec_ue, dec_err, dec_data};
  assign rd_valid = dec_vld;
endmodule

// File: rtl/ecc_adj_ram_chk.sv
module ecc_adj_ram_chk
  import ecc_adj_pkg::*;
#(
  parameter int PIPE_STAGE = 0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd_en,
  input logic              rd_valid,
  input logic [DATA_W+1:0] rd_q,
  input logic [CODE_W-1:0] dec_code,
  input logic [HIT_W-1:0]  hit_vec
);
  // R4: uncorrectable always comes with the error flag
  p_ue_has_err_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_q[DATA_W+1] |-> rd_q[DATA_W]);

  // R4: uncorrectable words carry the stored data bits unchanged
  p_ue_raw_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_q[DATA_W+1] |-> (rd_q[DATA_W-1:0] == dec_code[CODE_W-1:CHK_W]));

  // R3: no two correction candidates share a syndrome
  p_hit_unique_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));

  // R2: a matched candidate means a corrected, flagged word
  p_hit_flags_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (|hit_vec) |-> (rd_q[DATA_W] && !rd_q[DATA_W+1]));

  // R6: read latency
  if (PIPE_STAGE != 0) begin : g_lat2
    p_latency_r6: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |=> ##1 rd_valid);
  end else begin : g_lat1
    p_latency_r6: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |=> rd_valid);
  end
endmodule

bind ecc_adj_ram ecc_adj_ram_chk #(.PIPE_STAGE(PIPE_STAGE)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_valid(rd_valid),
  .rd_q(rd_q), .dec_code(dec_code), .hit_vec(hit_vec)
);

// File: tb/ecc_adj_ram_bench.sv
`timescale 1ns/1ps
module ecc_adj_ram_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, dbg_en = 1'b0, rd_en = 1'b0;
  logic [5:0]  wr_addr = '0, dbg_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0;
  logic [39:0] dbg_flip = '0;
  logic        v0, v1;
  logic [33:0] q0, q1;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  ecc_adj_ram #(.DEPTH(64), .PIPE_STAGE(0)) u_ecc_adj_ram (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .dbg_en(dbg_en), .dbg_addr(dbg_addr), .dbg_flip(dbg_flip),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_valid(v0), .rd_q(q0));

  ecc_adj_ram #(.DEPTH(64), .PIPE_STAGE(1)) u_ecc_adj_ram_p (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .dbg_en(dbg_en), .dbg_addr(dbg_addr), .dbg_flip(dbg_flip),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_valid(v1), .rd_q(q1));

  task automatic check(input string req, input logic [33:0] act, input logic [33:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Expected read word from the requirements: w adjacent flips starting at pos.
  function automatic logic [33:0] expect_word(input logic [31:0] d, input logic [39:0] m, input int w);
    if (m == '0) return {2'b00, d};
    if (w < 3)   return {2'b01, d};
    return {2'b11, d ^ m[39:8]};
  endfunction

  task automatic put(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic inject(input logic [5:0] a, input logic [39:0] m);
    @(negedge clk); dbg_en = 1'b1; dbg_addr = a; dbg_flip = m;
    @(negedge clk); dbg_en = 1'b0; dbg_flip = '0;
  endtask

  // R6: result one cycle later without the stage, two with it
  task automatic get(input logic [5:0] a, input logic [33:0] exp, input string req);
    @(negedge clk); rd_en = 1'b1; rd_addr = a;
    @(negedge clk); rd_en = 1'b0;
    check("R6 valid nopipe", {33'b0, v0}, 34'd1);
    check({req, " nopipe"}, q0, exp);
    @(negedge clk);
    check("R6 valid pipe", {33'b0, v1}, 34'd1);
    check({req, " pipe"}, q1, exp);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, d2;
    logic [5:0]  a;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    check("R9 q nopipe", q0, '0);
    check("R9 q pipe", q1, '0);
    check("R9 valid", {32'b0, v1, v0}, '0);

    // R1 / R5 clean round trips, including corner data
    for (int i = 0; i < 8; i++) begin
      d = (i == 0) ? 32'h0 : (i == 1) ? 32'hFFFF_FFFF : $urandom;
      a = 6'(i * 7);
      put(a, d);
      get(a, {2'b00, d}, "R1 clean");
    end

    // R2 / R3 / R4 exhaustive adjacent fault sweeps
    for (int w = 1; w <= 3; w++) begin
      for (int p = 0; p <= 40 - w; p++) begin
        logic [39:0] m;
        m = ((40'd1 << w) - 40'd1) << p;
        d = $urandom;
        a = 6'($urandom);
        put(a, d);
        inject(a, m);
        if (w == 1)      get(a, expect_word(d, m, w), "R2 single");
        else if (w == 2) get(a, expect_word(d, m, w), "R3 pair");
        else             get(a, expect_word(d, m, w), "R4 triple");
      end
    end

    // R5 field positions on all-ones data with a triple in the data field
    put(6'd5, 32'hFFFF_FFFF);
    inject(6'd5, 40'h70_0000_0000);
    get(6'd5, {2'b11, 32'h8FFF_FFFF}, "R5 format");

    // R7 write wins over fault injection at the same address
    d = $urandom;
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 6'd9; wr_data = d;
    dbg_en = 1'b1; dbg_addr = 6'd9; dbg_flip = 40'h700;
    @(negedge clk);
    wr_en = 1'b0; dbg_en = 1'b0; dbg_flip = '0;
    get(6'd9, {2'b00, d}, "R7 write wins");

    // R7 injection at another address leaves this word intact
    put(6'd10, d);
    inject(6'd11, 40'hFF);
    get(6'd10, {2'b00, d}, "R7 other addr");

    // R8 read during write returns old contents
    d = $urandom; d2 = ~d;
    put(6'd12, d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 6'd12; wr_data = d2;
    rd_en = 1'b1; rd_addr = 6'd12;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    check("R8 old nopipe", q0, {2'b00, d});
    @(negedge clk);
    check("R8 old pipe", q1, {2'b00, d});
    get(6'd12, {2'b00, d2}, "R8 new");

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule